// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block holds wall-clock time and calendar date as packed BCD fields: seconds, minutes, hours, day of week, day of month, month and a two-digit year counted from 2000. A one-cycle strobe arriving once per second advances the seconds. The carries ripple up through minutes, hours, weekday, date, month and year in that same cycle. Month lengths are derived from the month and year fields, so February gets a 29th day in leap years.

A register front end loads one field at a time. It supplies a 3-bit field selector and an 8-bit BCD value. The block masks off the bits that the field does not use. It also converts a 12-hour hour value into its internal 24-hour form.

The hour is always stored as 00 to 23. A mode input chooses whether it is presented in 24-hour form or in 12-hour form with a PM flag. The same mode input controls how hour writes are interpreted. All fields are presented continuously on output ports in the register encoding.

Top module: `cal_timekeeper`

## Requirements
- R1: After synchronous reset the fields read seconds 00, minutes 00, hours 00 (24-hour form), weekday 01, date 01, month 01, year 00.
- R2: Selector 0 loads seconds and selector 1 loads minutes. Both take BCD from data bits 6:0, and bit 7 is discarded, so it reads back as 0.
- R3: A tick advances seconds by one. 59 rolls to 00 and carries into minutes, and minutes 59 roll to 00 and carry into hours. Without a tick or a write, no field changes.
- R4: Selector 2 loads hours. In 24-hour mode (mode input low) it takes BCD 00 to 23 from bits 5:0, and 24-hour presentation uses the same form. Hours roll from 23 to 00, and that rollover advances both the weekday and the date.
- R5: With the mode input high, the hour output reads BCD 1 to 12 in bits 4:0, with bit 5 set for PM. Stored hour 0 reads 0x12, hour 12 reads 0x32, and hours 13 to 23 read 0x21 to 0x31.
- R6: In 12-hour mode, an hour write takes bits 4:0 as BCD and adds 12 when bit 5 is set. A result of 12 or 24 is then reduced by 12. So 0x12 stores 00, 0x32 stores 12, and 0x21 stores 13.
- R7: Selector 3 loads the weekday directly from bits 2:0, for values 1 to 7. The weekday counts 1 up to 7 and wraps to 1 on each day rollover.
- R8: The date rolls to 01 after the last day of the month. January, March, May, July, August, October and December have 31 days. April, June, September and November have 30. February has 29 days when the binary year is a multiple of LEAP_PERIOD (default 4, year 00 included) and 28 otherwise.
- R9: Month 12 rolls to 01 and carries into the year, and year 99 wraps to 00.
- R10: A write in the same cycle as a tick sets the written field to the written value, and the tick's carry into that field is lost. Carries to other fields come from the values held before that cycle. Selector 7 changes nothing.
- R11: Selector 4 loads the date from bits 5:0, selector 5 loads the month from bits 4:0, and selector 6 loads the year from all 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe, once per second |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field selector: 0 sec, 1 min, 2 hour, 3 weekday, 4 date, 5 month, 6 year, 7 none |
| wr_data_i | input | 8 | BCD value to load |
| mode12_i | input | 1 | 1: 12-hour hour format with PM flag; 0: 24-hour |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, in the format chosen by mode12_i |
| wday_o | output | 8 | Weekday 1 to 7 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |

## Verification
The bench builds the block with LEAP_PERIOD at its default of 4. This makes the leap-year rule reachable at years 24 and 00, with 23 as the common-year contrast.

The 3-bit selector and 8-bit data width leave the unused selector 7 and each field's masked high bits reachable. Both are exercised through writes whose dropped bits are set.

Full cascades are staged by loading fields just short of rollover. These reach the year 99 wrap and the 12-hour noon and midnight encodings.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int FW    = 8;
    localparam int SEL_W = 3;
    localparam int NF    = 7;

    typedef logic [FW-1:0] bcd_t;

    typedef enum logic [SEL_W-1:0] {
        F_SEC   = 3'd0,
        F_MIN   = 3'd1,
        F_HOUR  = 3'd2,
        F_WDAY  = 3'd3,
        F_DATE  = 3'd4,
        F_MON   = 3'd5,
        F_YEAR  = 3'd6,
        F_SPARE = 3'd7
    } field_e;

    // Field order matches the packed array index (year at the top).
    typedef struct packed {
        bcd_t year;
        bcd_t mon;
        bcd_t date;
        bcd_t wday;
        bcd_t hour;
        bcd_t min;
        bcd_t sec;
    } cal_t;

    function automatic logic [6:0] bcd2bin(bcd_t d);
        int v;
        v = int'(d[7:4]) * 10 + int'(d[3:0]);
        return 7'(v);
    endfunction

    function automatic bcd_t bin2bcd(logic [6:0] b);
        int t;
        int o;
        t = int'(b) / 10;
        o = int'(b) % 10;
        return {4'(t), 4'(o)};
    endfunction

    function automatic bcd_t bcd_inc(bcd_t d);
        if (d[3:0] >= 4'd9) return {d[7:4] + 4'd1, 4'd0};
        return {d[7:4], d[3:0] + 4'd1};
    endfunction

    function automatic bcd_t month_days(bcd_t mon, bcd_t yr, int leap_period);
        logic leap;
        leap = ((int'(bcd2bin(yr)) % leap_period) == 0);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // 12-hour register value -> stored 24-hour BCD
    function automatic bcd_t hour_from_12(bcd_t d);
        logic [6:0] b;
        b = bcd2bin({3'b000, d[4:0]});
        if (d[5]) b = b + 7'd12;
        if (b == 7'd12 || b == 7'd24) b = b - 7'd12;
        return bin2bcd(b);
    endfunction

    // stored 24-hour BCD -> 12-hour register value
    function automatic bcd_t hour_to_12(bcd_t h);
        logic [6:0] b;
        b = bcd2bin(h);
        if (b == 7'd0)  return 8'h12;
        if (b < 7'd12)  return bin2bcd(b);
        if (b == 7'd12) return 8'h32;
        return 8'h20 | bin2bcd(b - 7'd12);
    endfunction

    function automatic bcd_t field_first(int idx);
        if (idx == int'(F_WDAY) || idx == int'(F_DATE) || idx == int'(F_MON))
            return 8'h01;
        return 8'h00;
    endfunction

endpackage

// File: rtl/cal_bcd_counter.sv
module cal_bcd_counter
    import cal_pkg::*;
#(
    parameter bcd_t FIRST = 8'h00
) (
    input  logic clk,
    input  logic rst,
    input  logic adv_i,
    input  logic ld_i,
    input  bcd_t ld_val_i,
    input  bcd_t limit_i,
    output bcd_t val_o,
    output logic carry_o
);

    bcd_t cnt_q;
    logic at_end;

    assign at_end  = (cnt_q >= limit_i);
    assign carry_o = adv_i && at_end;
    assign val_o   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= FIRST;
        else if (ld_i)
            cnt_q <= ld_val_i;
        else if (adv_i)
            cnt_q <= at_end ? FIRST : bcd_inc(cnt_q);
    end

endmodule

// File: rtl/cal_wr_format.sv
module cal_wr_format
    import cal_pkg::*;
(
    input  bcd_t                   data_i,
    input  logic                   mode12_i,
    output logic [NF-1:0][FW-1:0]  val_o
);

    always_comb begin
        val_o         = '0;
        val_o[F_SEC]  = data_i & 8'h7F;
        val_o[F_MIN]  = data_i & 8'h7F;
        val_o[F_HOUR] = mode12_i ? hour_from_12(data_i) : (data_i & 8'h3F);
        val_o[F_WDAY] = data_i & 8'h07;
        val_o[F_DATE] = data_i & 8'h3F;
        val_o[F_MON]  = data_i & 8'h1F;
        val_o[F_YEAR] = data_i;
    end

endmodule

// File: rtl/cal_view.sv
module cal_view
    import cal_pkg::*;
(
    input  cal_t st_i,
    input  logic mode12_i,
    output cal_t view_o
);

    always_comb begin
        view_o = st_i;
        if (mode12_i) view_o.hour = hour_to_12(st_i.hour);
    end

endmodule

// File: rtl/cal_timekeeper.sv
module cal_timekeeper
    import cal_pkg::*;
#(
    parameter int LEAP_PERIOD = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [FW-1:0]    wr_data_i,
    input  logic             mode12_i,
    output logic [FW-1:0]    sec_o,
    output logic [FW-1:0]    min_o,
    output logic [FW-1:0]    hour_o,
    output logic [FW-1:0]    wday_o,
    output logic [FW-1:0]    date_o,
    output logic [FW-1:0]    month_o,
    output logic [FW-1:0]    year_o
);

    logic [NF-1:0][FW-1:0] ld_val;
    logic [NF-1:0][FW-1:0] limit;
    logic [NF-1:0][FW-1:0] cur;
    logic [NF-1:0]         adv;
    logic [NF-1:0]         carry;
    logic                  day_roll;
    cal_t                  stored;
    cal_t                  shown;

    cal_wr_format u_fmt (
        .data_i   (wr_data_i),
        .mode12_i (mode12_i),
        .val_o    (ld_val)
    );

    // Carry network: time chain, then day fans out to weekday and date.
    assign day_roll   = carry[F_HOUR];
    assign adv[F_SEC]  = tick_i;
    assign adv[F_MIN]  = carry[F_SEC];
    assign adv[F_HOUR] = carry[F_MIN];
    assign adv[F_WDAY] = day_roll;
    assign adv[F_DATE] = day_roll;
    assign adv[F_MON]  = carry[F_DATE];
    assign adv[F_YEAR] = carry[F_MON];

    always_comb begin
        limit[F_SEC]  = 8'h59;
        limit[F_MIN]  = 8'h59;
        limit[F_HOUR] = 8'h23;
        limit[F_WDAY] = 8'h07;
        limit[F_DATE] = month_days(cur[F_MON], cur[F_YEAR], LEAP_PERIOD);
        limit[F_MON]  = 8'h12;
        limit[F_YEAR] = 8'h99;
    end

    for (genvar g = 0; g < NF; g++) begin : g_field
        cal_bcd_counter #(
            .FIRST (field_first(g))
        ) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .adv_i    (adv[g]),
            .ld_i     (wr_en_i && (wr_sel_i == SEL_W'(g))),
            .ld_val_i (ld_val[g]),
            .limit_i  (limit[g]),
            .val_o    (cur[g]),
            .carry_o  (carry[g])
        );
    end

    assign stored = cal_t'(cur);

    cal_view u_view (
        .st_i     (stored),
        .mode12_i (mode12_i),
        .view_o   (shown)
    );

    assign sec_o   = shown.sec;
    assign min_o   = shown.min;
    assign hour_o  = shown.hour;
    assign wday_o  = shown.wday;
    assign date_o  = shown.date;
    assign month_o = shown.mon;
    assign year_o  = shown.year;

endmodule

// File: rtl/cal_timekeeper_chk.sv
module cal_timekeeper_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_i,
    input logic       wr_en_i,
    input logic [2:0] wr_sel_i,
    input logic [7:0] wr_data_i,
    input logic       mode12_i,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] date_o,
    input logic [7:0] year_o
);

    // R3: seconds wrap on tick
    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !wr_en_i && sec_o == 8'h59) |=> (sec_o == 8'h00));

    // R3: minutes carry
    a_r3_min_carry: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !wr_en_i && sec_o == 8'h59 && min_o == 8'h59) |=> (min_o == 8'h00));

    // R3: idle holds
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !wr_en_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(date_o) && $stable(year_o)));

    // R2/R10: seconds write wins over tick
    a_r10_sec_write_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sel_i == 3'd0) |=> (sec_o == {1'b0, $past(wr_data_i[6:0])}));

    // R10: selector 7 leaves fields alone
    a_r10_spare_sel: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sel_i == 3'd7 && !tick_i) |=> ($stable(sec_o) && $stable(date_o) && $stable(year_o)));

    // R5: 12-hour view never shows hour zero
    a_r5_no_zero_hour: assert property (@(posedge clk) disable iff (rst)
        mode12_i |-> (hour_o[4:0] != 5'd0));

endmodule

bind cal_timekeeper cal_timekeeper_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .mode12_i  (mode12_i),
    .sec_o     (sec_o),
    .min_o     (min_o),
    .hour_o    (hour_o),
    .date_o    (date_o),
    .year_o    (year_o)
);

// File: tb/cal_timekeeper_test.sv
module cal_timekeeper_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_sel_i = 3'd0;
    logic [7:0] wr_data_i = 8'h00;
    logic       mode12_i = 1'b0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    cal_timekeeper uut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .mode12_i(mode12_i),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // one clock cycle with the given stimulus; outputs sampled 1 unit after the edge
    task automatic cyc(input logic t, input logic w, input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        tick_i = t; wr_en_i = w; wr_sel_i = s; wr_data_i = d;
        @(posedge clk);
        #1;
        tick_i = 1'b0; wr_en_i = 1'b0;
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        cyc(1'b0, 1'b1, s, d);
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
    endtask

    task automatic t_reset;
        chk("R1 sec", sec_o, 8'h00);   chk("R1 min", min_o, 8'h00);
        chk("R1 hour", hour_o, 8'h00); chk("R1 wday", wday_o, 8'h01);
        chk("R1 date", date_o, 8'h01); chk("R1 month", month_o, 8'h01);
        chk("R1 year", year_o, 8'h00);
    endtask

    task automatic t_field_masks;
        wr(3'd0, 8'hA5); chk("R2 sec bit7 dropped", sec_o, 8'h25);
        wr(3'd1, 8'hD9); chk("R2 min bit7 dropped", min_o, 8'h59);
        wr(3'd2, 8'hD7); chk("R4 hour 24h mask", hour_o, 8'h17);
        wr(3'd3, 8'hFB); chk("R7 wday mask", wday_o, 8'h03);
        wr(3'd4, 8'hC7); chk("R11 date mask", date_o, 8'h07);
        wr(3'd5, 8'hF2); chk("R11 month mask", month_o, 8'h12);
        wr(3'd6, 8'h47); chk("R11 year", year_o, 8'h47);
    endtask

    task automatic t_full_cascade;
        mode12_i = 1'b0;
        wr(3'd3, 8'h07); wr(3'd4, 8'h31); wr(3'd5, 8'h12); wr(3'd6, 8'h99);
        set_time(8'h23, 8'h59, 8'h58);
        cyc(1'b1, 1'b0, 3'd0, 8'h00);
        chk("R3 sec step", sec_o, 8'h59); chk("R3 min held", min_o, 8'h59);
        repeat (3) cyc(1'b0, 1'b0, 3'd0, 8'h00);
        chk("R3 idle no change", sec_o, 8'h59);
        cyc(1'b1, 1'b0, 3'd0, 8'h00);
        chk("R3 sec wrap", sec_o, 8'h00);   chk("R3 min wrap", min_o, 8'h00);
        chk("R4 hour wrap", hour_o, 8'h00); chk("R7 wday wrap", wday_o, 8'h01);
        chk("R4 date wrap", date_o, 8'h01); chk("R9 month wrap", month_o, 8'h01);
        chk("R9 year wrap", year_o, 8'h00);
    endtask

    task automatic t_12h_view;
        mode12_i = 1'b0; wr(3'd2, 8'h00);
        mode12_i = 1'b1; #1; chk("R5 midnight", hour_o, 8'h12);
        mode12_i = 1'b0; wr(3'd2, 8'h12);
        mode12_i = 1'b1; #1; chk("R5 noon", hour_o, 8'h32);
        mode12_i = 1'b0; wr(3'd2, 8'h13);
        mode12_i = 1'b1; #1; chk("R5 13h", hour_o, 8'h21);
        mode12_i = 1'b0; wr(3'd2, 8'h09);
        mode12_i = 1'b1; #1; chk("R5 9h", hour_o, 8'h09);
        mode12_i = 1'b0; wr(3'd2, 8'h23);
        mode12_i = 1'b1; #1; chk("R5 23h", hour_o, 8'h31);
        mode12_i = 1'b0; #1;
    endtask

    task automatic t_12h_write;
        mode12_i = 1'b1; wr(3'd2, 8'h12);
        mode12_i = 1'b0; #1; chk("R6 12AM", hour_o, 8'h00);
        mode12_i = 1'b1; wr(3'd2, 8'h32);
        mode12_i = 1'b0; #1; chk("R6 12PM", hour_o, 8'h12);
        mode12_i = 1'b1; wr(3'd2, 8'h21);
        mode12_i = 1'b0; #1; chk("R6 1PM", hour_o, 8'h13);
        mode12_i = 1'b1; wr(3'd2, 8'h05);
        mode12_i = 1'b0; #1; chk("R6 5AM", hour_o, 8'h05);
        // 11:59:59 PM in 12-hour mode rolls to 12 AM and next weekday
        mode12_i = 1'b1;
        wr(3'd3, 8'h02); wr(3'd4, 8'h10); wr(3'd5, 8'h03);
        set_time(8'h31, 8'h59, 8'h59);
        cyc(1'b1, 1'b0, 3'd0, 8'h00);
        chk("R5 roll to 12AM", hour_o, 8'h12); chk("R7 wday step", wday_o, 8'h03);
        chk("R4 date step", date_o, 8'h11);
        mode12_i = 1'b0; #1;
    endtask

    task automatic day_end(input logic [7:0] y, input logic [7:0] m, input logic [7:0] d,
                           input logic [7:0] exp_d, input logic [7:0] exp_m, input string tag);
        wr(3'd6, y); wr(3'd5, m); wr(3'd4, d);
        set_time(8'h23, 8'h59, 8'h59);
        cyc(1'b1, 1'b0, 3'd0, 8'h00);
        chk({"R8 date ", tag}, date_o, exp_d);
        chk({"R8 month ", tag}, month_o, exp_m);
    endtask

    task automatic t_month_len;
        mode12_i = 1'b0;
        day_end(8'h24, 8'h02, 8'h28, 8'h29, 8'h02, "leap feb28");
        day_end(8'h24, 8'h02, 8'h29, 8'h01, 8'h03, "leap feb29");
        day_end(8'h23, 8'h02, 8'h28, 8'h01, 8'h03, "common feb28");
        day_end(8'h00, 8'h02, 8'h28, 8'h29, 8'h02, "year00 feb");
        day_end(8'h23, 8'h04, 8'h30, 8'h01, 8'h05, "april");
        day_end(8'h23, 8'h01, 8'h30, 8'h31, 8'h01, "january");
    endtask

    task automatic t_priority;
        logic [7:0] snap [7];
        mode12_i = 1'b0;
        set_time(8'h05, 8'h10, 8'h59);
        cyc(1'b1, 1'b1, 3'd0, 8'h30);
        chk("R10 sec written", sec_o, 8'h30); chk("R10 min carried", min_o, 8'h11);
        wr(3'd0, 8'h59);
        cyc(1'b1, 1'b1, 3'd1, 8'h20);
        chk("R10 sec rolled", sec_o, 8'h00); chk("R10 min written", min_o, 8'h20);
        chk("R10 hour from old min", hour_o, 8'h05);
        snap = '{sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o};
        wr(3'd7, 8'hFF);
        chk("R10 sel7 sec", sec_o, snap[0]);   chk("R10 sel7 min", min_o, snap[1]);
        chk("R10 sel7 hour", hour_o, snap[2]); chk("R10 sel7 wday", wday_o, snap[3]);
        chk("R10 sel7 date", date_o, snap[4]); chk("R10 sel7 month", month_o, snap[5]);
        chk("R10 sel7 year", year_o, snap[6]);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        t_reset();
        t_field_masks();
        t_full_cascade();
        t_12h_view();
        t_12h_write();
        t_month_len();
        t_priority();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule